// File: doc/BRIEF.md
# Cross-Word Alignment Shifter

This block realigns a stream of source words so that data beginning at any bit offset inside a word lines up with destination word boundaries. Every accepted word is paired with the word accepted just before it in the same row. The pair is shifted by a programmed amount, and one full output word comes out for each input word. A direction bit selects a left or a right shift.

The held word is cleared whenever a row begins, so a row never picks up bits from the end of the row before it. A channel whose data is always word-aligned, such as a fill pattern, uses an instance built with shifting disabled. That instance passes words through untouched. The output is registered, and a word's result appears one clock after the word is presented.

Top module: `xword_align`

## Requirements
- R1: While `rst_n` is low at a clock edge, and until the first valid word after reset, `out_valid` is 0 and `out_word` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1, and 0 otherwise.
- R3: With `dir_right`=0 and shift amount s, the result is the low 16 bits of (cur << s) OR'd with (prev >> (16-s)). Here cur is the accepted word and prev is the held word.
- R4: With `dir_right`=1 and shift amount s, the result is (cur >> s) OR'd with the low 16 bits of (prev << (16-s)), which puts the low bits of prev into the vacated high bits.
- R5: A shift amount of 0 gives the current word unchanged in either direction, with nothing taken from the held word.
- R6: A word presented with `row_start`=1 is combined with an all-zero held word. It then becomes the held word for the next word.
- R7: The held word changes only when `in_valid`=1, apart from clearing by `row_start`. While `in_valid`=0, `out_word` keeps its last value.
- R8: `row_start`=1 with `in_valid`=0 clears the held word, so the next valid word is combined with zero.
- R9: An instance with parameter `SHIFT_EN`=0 outputs each valid word unchanged, whatever the shift amount and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is presented this cycle |
| row_start | input | 1 | Start of a new row; clears the held word |
| in_word | input | W (16) | Source word |
| shamt | input | $clog2(W) (4) | Shift amount |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| out_valid | output | 1 | Aligned word is valid |
| out_word | output | W (16) | Aligned word |

## Verification
Every result, including `out_valid`, is due exactly one clock after the cycle that presented the input word, because one register stands between the inputs and the outputs. The bench drives inputs on the falling edge and samples outputs on the next falling edge, half a cycle after the capturing rising edge. A reference model updates its own held word in step with each driven word. Gaps and row-start-only cycles are checked on that same one-cycle boundary, to confirm that `out_valid` drops and `out_word` holds.

// File: rtl/xa_pkg.sv
// Shared definitions for the cross-word alignment shifter.
// Assumes a power-of-two word width so the shift amount fits in clog2 bits.
package xa_pkg;
    typedef enum logic {
        XA_DIR_LEFT  = 1'b0,
        XA_DIR_RIGHT = 1'b1
    } xa_dir_e;
endpackage

// File: rtl/xa_prev_hold.sv
// Holds the word accepted last in the current row.
// Presents zero as the previous word when a row starts, and clears on a
// row start that carries no word. Updates only on accepted words.
module xa_prev_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         row_start,
    input  logic [W-1:0] in_word,
    output logic [W-1:0] prev_eff
);
    logic [W-1:0] prev_q;

    // Previous-word storage: load on valid, clear on bare row start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (in_valid) begin
            prev_q <= in_word;
        end else if (row_start) begin
            prev_q <= '0;
        end
    end

    // Effective previous word: a new row sees zero.
    always_comb begin
        prev_eff = row_start ? '0 : prev_q;
    end
endmodule

// File: rtl/xa_funnel.sv
// Two-word funnel shifter. Joins the current and previous words and
// extracts one word shifted left or right. With SHIFT_EN=0 it is a wire.
module xa_funnel
    import xa_pkg::*;
#(
    parameter int W        = 16,
    parameter bit SHIFT_EN = 1'b1,
    localparam int SHW     = $clog2(W)
) (
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   prev,
    input  logic [SHW-1:0] shamt,
    input  logic           dir_right,
    output logic [W-1:0]   result
);
    generate
        if (SHIFT_EN) begin : g_shift
            logic [2*W-1:0] pair_l;
            logic [2*W-1:0] pair_r;
            logic [2*W-1:0] sh_l;
            logic [2*W-1:0] sh_r;

            // Left: current word on top, previous below feeds low bits.
            always_comb begin
                pair_l = {cur, prev};
                sh_l   = pair_l << shamt;
            end

            // Right: previous word on top feeds the vacated high bits.
            always_comb begin
                pair_r = {prev, cur};
                sh_r   = pair_r >> shamt;
            end

            // Direction select.
            always_comb begin
                if (xa_dir_e'(dir_right) == XA_DIR_RIGHT) begin
                    result = sh_r[W-1:0];
                end else begin
                    result = sh_l[2*W-1:W];
                end
            end
        end else begin : g_pass
            logic unused_ok;
            // Aligned channel: forward the word as is.
            always_comb begin
                unused_ok = ^{prev, shamt, dir_right};
                result    = cur;
            end
        end
    endgenerate
endmodule

// File: rtl/xa_out_reg.sv
// Output stage: registers the aligned word and its valid flag.
// The word holds its last value across cycles without a valid input.
module xa_out_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic         q_valid,
    output logic [W-1:0] q
);
    // Valid flag follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
        end else begin
            q_valid <= in_valid;
        end
    end

    // Data register loads only on an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (in_valid) begin
            q <= d;
        end
    end
endmodule

// File: rtl/xword_align.sv
// Cross-word alignment shifter top. Per channel: previous-word hold,
// funnel shift, registered output with one-cycle latency.
// Assumes row_start is asserted on (or before) the first word of a row.
module xword_align #(
    parameter int W        = 16,
    parameter bit SHIFT_EN = 1'b1,
    localparam int SHW     = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           row_start,
    input  logic [W-1:0]   in_word,
    input  logic [SHW-1:0] shamt,
    input  logic           dir_right,
    output logic           out_valid,
    output logic [W-1:0]   out_word
);
    logic [W-1:0] prev_eff;
    logic [W-1:0] aligned;

    xa_prev_hold #(.W(W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .row_start (row_start),
        .in_word   (in_word),
        .prev_eff  (prev_eff)
    );

    xa_funnel #(.W(W), .SHIFT_EN(SHIFT_EN)) u_funnel (
        .cur       (in_word),
        .prev      (prev_eff),
        .shamt     (shamt),
        .dir_right (dir_right),
        .result    (aligned)
    );

    xa_out_reg #(.W(W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d        (aligned),
        .q_valid  (out_valid),
        .q        (out_word)
    );
endmodule

// File: rtl/xword_align_chk.sv
// Assertion checker bound to xword_align. Observes ports only.
module xword_align_chk #(
    parameter int W        = 16,
    parameter bit SHIFT_EN = 1'b1,
    localparam int SHW     = $clog2(W)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           row_start,
    input logic [W-1:0]   in_word,
    input logic [SHW-1:0] shamt,
    input logic           dir_right,
    input logic           out_valid,
    input logic [W-1:0]   out_word
);
    // R2: valid follows the input strobe by one cycle
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: output word holds through cycles without input
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));

    // R5: zero shift returns the current word
    a_r5_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shamt == '0) |=> (out_word == $past(in_word)));

    // R6: first word of a row, left: no bits from a previous word
    a_r6_row_left: assert property (@(posedge clk) disable iff (!rst_n)
        (SHIFT_EN && in_valid && row_start && !dir_right)
        |=> (out_word == W'($past(in_word) << $past(shamt))));

    // R6: first word of a row, right
    a_r6_row_right: assert property (@(posedge clk) disable iff (!rst_n)
        (SHIFT_EN && in_valid && row_start && dir_right)
        |=> (out_word == ($past(in_word) >> $past(shamt))));

    // R9: pass-through instance forwards words untouched
    a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!SHIFT_EN && in_valid) |=> (out_word == $past(in_word)));
endmodule

bind xword_align xword_align_chk #(.W(W), .SHIFT_EN(SHIFT_EN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .row_start (row_start),
    .in_word   (in_word),
    .shamt     (shamt),
    .dir_right (dir_right),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/test_xword_align.sv
`timescale 1ns/1ps
module test_xword_align;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        row_start;
    logic [15:0] in_word;
    logic [3:0]  shamt;
    logic        dir_right;
    logic        out_valid, p_valid;
    logic [15:0] out_word, p_word;

    int errors = 0;
    int checks = 0;
    logic [15:0] mprev;   // bench model of the held word
    logic [15:0] mexp;    // expected result of last valid word
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    xword_align i_xword_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_start(row_start),
        .in_word(in_word), .shamt(shamt), .dir_right(dir_right),
        .out_valid(out_valid), .out_word(out_word));

    xword_align #(.SHIFT_EN(1'b0)) i_xword_align_pass (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_start(row_start),
        .in_word(in_word), .shamt(shamt), .dir_right(dir_right),
        .out_valid(p_valid), .out_word(p_word));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference alignment from the requirement formulas.
    function automatic logic [15:0] ref_align(logic [15:0] c, logic [15:0] p,
                                              int s, bit right);
        logic [31:0] c32 = {16'h0, c};
        logic [31:0] p32 = {16'h0, p};
        logic [31:0] r;
        if (!right) r = (c32 << s) | (p32 >> (16 - s));
        else        r = (c32 >> s) | (p32 << (16 - s));
        return r[15:0];
    endfunction

    // Present one cycle of stimulus; returns after the output is due.
    task automatic step(bit v, bit rs, logic [15:0] w, int s, bit right);
        in_valid  = v;
        row_start = rs;
        in_word   = w;
        shamt     = 4'(s);
        dir_right = right;
        if (rs) mprev = 16'h0;
        if (v) begin
            mexp  = ref_align(w, mprev, s, right);
            mprev = w;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 16'h0, 0, 0);
    endtask

    task automatic t_reset();
        rst_n = 0; in_valid = 0; row_start = 0; in_word = 0; shamt = 0; dir_right = 0;
        mprev = 0; mexp = 0;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", 32'(out_valid), 0);
        check("R1 out_word in reset", 32'(out_word), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 0);
        check("R1 out_word after reset", 32'(out_word), 0);
    endtask

    task automatic t_left_stream();
        logic [15:0] ws [4] = '{16'hA5C3, 16'h1234, 16'hFFFF, 16'h0F0F};
        for (int s = 1; s < 16; s += 5) begin
            for (int i = 0; i < 4; i++) begin
                step(1, i == 0, ws[i], s, 0);
                check($sformatf("R3 left s=%0d i=%0d", s, i), 32'(out_word), 32'(mexp));
                check("R2 valid after word", 32'(out_valid), 1);
            end
        end
        idle();
        check("R2 valid low after gap", 32'(out_valid), 0);
    endtask

    task automatic t_right_stream();
        logic [15:0] ws [4] = '{16'h8001, 16'hC0DE, 16'h7E57, 16'h0001};
        for (int s = 3; s < 16; s += 6) begin
            for (int i = 0; i < 4; i++) begin
                step(1, i == 0, ws[i], s, 1);
                check($sformatf("R4 right s=%0d i=%0d", s, i), 32'(out_word), 32'(mexp));
            end
        end
        idle();
    endtask

    task automatic t_zero_shift();
        step(1, 1, 16'h1357, 0, 0);
        step(1, 0, 16'h2468, 0, 0);
        check("R5 zero shift left", 32'(out_word), 32'h2468);
        step(1, 0, 16'h9ABC, 0, 1);
        check("R5 zero shift right", 32'(out_word), 32'h9ABC);
        idle();
    endtask

    task automatic t_row_clear();
        step(1, 1, 16'hFFFF, 8, 0);
        step(1, 0, 16'hFFFF, 8, 0);
        check("R3 carry within row", 32'(out_word), 32'hFFFF);
        step(1, 1, 16'h0001, 8, 0);
        check("R6 row start left zero prev", 32'(out_word), 32'h0100);
        step(1, 0, 16'hFFFF, 8, 1);
        step(1, 1, 16'h8000, 4, 1);
        check("R6 row start right zero prev", 32'(out_word), 32'h0800);
        idle();
    endtask

    task automatic t_gap_hold();
        step(1, 1, 16'h00F0, 4, 0);
        step(0, 0, 16'hDEAD, 4, 0);
        check("R7 word holds on gap", 32'(out_word), 32'h0F00);
        check("R7 valid low on gap", 32'(out_valid), 0);
        step(1, 0, 16'h0000, 4, 0);
        check("R7 prev unchanged by invalid word", 32'(out_word), 32'h0000);
        idle();
    endtask

    task automatic t_row_only_clear();
        step(1, 1, 16'hFFFF, 4, 0);
        step(0, 1, 16'h0000, 4, 0);
        check("R8 bare row start no output", 32'(out_valid), 0);
        step(1, 0, 16'h0001, 4, 0);
        check("R8 prev cleared by bare row start", 32'(out_word), 32'h0010);
        idle();
    endtask

    task automatic t_pass();
        step(1, 1, 16'hBEEF, 7, 0);
        check("R9 pass left", 32'(p_word), 32'hBEEF);
        step(1, 0, 16'h4321, 11, 1);
        check("R9 pass right", 32'(p_word), 32'h4321);
        check("R9 pass valid", 32'(p_valid), 1);
        idle();
    endtask

    initial begin
        t_reset();
        t_left_stream();
        t_right_stream();
        t_zero_shift();
        t_row_clear();
        t_gap_hold();
        t_row_only_clear();
        t_pass();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule